// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads up to two descriptor words from a page table held in memory, then decides whether the access may go ahead. A caller offers one translation at a time on a valid/ready request channel. With that request it gives the access kind, a user/privileged flag and the translation settings. The settings are the table base, the 16-entry domain access word, a process identifier, the translation enable and a two-bit selector that governs access-permission value 0. The block samples all of these when it accepts the request.

Descriptor words are fetched one at a time over a request/response port. The walker keeps `mem_req_valid` and `mem_addr` steady until `mem_req_ready` is high. It then takes the first cycle that has `mem_rsp_valid` as the reply. It never has more than one read outstanding. The outcome is a physical address and the granted read/write rights, or a fault with an encoded status word. The outcome is offered on a result channel and held unchanged until `res_ready` accepts it. `req_ready` is high only when no translation is in flight.

A fault also updates one of two fault-record pairs, each made of a status word and a faulting address. Instruction fetches write the instruction pair. All other accesses write the data pair.

Top module: `pagewalk_unit`

## Requirements
- R1: A virtual address below 0x02000000 has the process identifier added to it (modulo 2^32) before any other use. Addresses from 0x02000000 upward pass unchanged.
- R2: With translation disabled, the result carries the remapped address, grants both read and write, reports no fault and makes no memory read.
- R3: The first memory read is at {table base[31:14], remapped address[31:20], 2'b00}.
- R4: A first-level descriptor type (bits [1:0]) of 0 faults with code 5 and makes no second read.
- R5: The domain number is first-level bits [8:5]. Its 2-bit field sits at bits [2n+1:2n] of the domain access word. Field 0 or 2 faults, with code 9 for a section (type 2) or code 11 for a page table (type 1 or 3), and makes no second read. Field 3 grants read and write without an AP check. Field 1 applies the AP check.
- R6: A section (type 2) maps to {descriptor[31:20], address[19:0]}, and its AP is descriptor bits [11:10].
- R7: For a first-level type of 1 or 3 with domain field 1 or 3, the second read is at {descriptor[31:10], address[19:12], 2'b00}. A second-level type (bits [1:0]) of 0 faults with code 7.
- R8: A second-level type 1 maps to {d[31:16], address[15:0]} and type 2 maps to {d[31:12], address[11:0]}. For both, the AP is d[5+2k:4+2k], where k = address[11:10]. Type 3 maps to {d[31:10], address[9:0]} with AP d[5:4]. Type 3 faults with code 7 when the first-level type was 1.
- R9: AP 3 grants read and write. AP 2 grants read, and grants write only when privileged. AP 1 grants read and write when privileged and nothing to a user. AP 0 never grants write. Its read right follows the selector: 1 gives privileged-only read, 2 gives read for all, and 0 or 3 gives none. Access codes are 0 read, 1 write and 2 fetch; fetch (and 3) needs read. A missing right faults with code 13 for a section and 15 for a page, and a faulting result grants nothing.
- R10: The status word is {24'b0, domain number, code}, and it is 0 when there is no fault. A fault with access code 2 writes the status and the original, unremapped address into the instruction pair. Any other fault writes the data pair. The other pair is left unchanged.
- R11: `req_ready` is high only when idle. `mem_req_valid` and `mem_addr` hold until accepted. The result and all of its fields hold until `res_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request taken |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access code: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 = user access, 0 = privileged |
| cfg_mmu_on | input | 1 | Translation enable |
| cfg_ap0_mode | input | 2 | Read rights for AP 0 |
| cfg_ttb | input | 32 | Table base (bits [31:14] used) |
| cfg_dacr | input | 32 | Sixteen 2-bit domain access fields |
| cfg_pid | input | 32 | Process identifier added to low addresses |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 32 | Descriptor word address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result taken |
| res_fault | output | 1 | Translation faulted |
| res_pa | output | 32 | Physical address (0 on fault) |
| res_rd_ok | output | 1 | Read granted |
| res_wr_ok | output | 1 | Write granted |
| res_status | output | 32 | Fault status word |
| data_fstat | output | 32 | Data fault status record |
| data_faddr | output | 32 | Data fault address record |
| inst_fstat | output | 32 | Instruction fault status record |
| inst_faddr | output | 32 | Instruction fault address record |

## Verification
Several rules are checked by assertions on every cycle. A pending memory read and an offered result must stay stable. Nothing is in flight while the walker is idle. A transaction with translation disabled never touches memory. A faulting result grants no rights. The fault-record pair that does not belong to the access kind stays unchanged. The bench scenarios alone can show the arithmetic of the walk: the remap, both descriptor addresses, the address mapping for every descriptor type, the sub-page AP selection, the full AP/domain/selector/user/access grid and the encoded fault codes. The bench sweeps these against a model it computes itself.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int VA_W  = 32;
  localparam int DOM_W = 4;
  localparam int FC_W  = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_CHECK, S_DONE
  } walk_state_t;

  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [FC_W-1:0] FC_SEC_XLAT  = 4'd5;
  localparam logic [FC_W-1:0] FC_PAGE_XLAT = 4'd7;
  localparam logic [FC_W-1:0] FC_SEC_DOM   = 4'd9;
  localparam logic [FC_W-1:0] FC_PAGE_DOM  = 4'd11;
  localparam logic [FC_W-1:0] FC_SEC_PERM  = 4'd13;
  localparam logic [FC_W-1:0] FC_PAGE_PERM = 4'd15;

  // 2-bit access field of one domain
  function automatic logic [1:0] dom_field(input logic [VA_W-1:0] dacr,
                                           input logic [DOM_W-1:0] dom);
    logic [DOM_W:0] idx;
    idx = {dom, 1'b0};
    return dacr[idx +: 2];
  endfunction

  // first-level word points at a table and its domain lets the walk go on
  function automatic logic l1_needs_l2(input logic [VA_W-1:0] desc,
                                       input logic [VA_W-1:0] dacr);
    logic [1:0] df;
    df = dom_field(dacr, desc[8:5]);
    return desc[0] && df[0];
  endfunction
endpackage

// File: rtl/pw_remap.sv
module pw_remap #(
  parameter int          AW    = 32,
  parameter logic [31:0] LIMIT = 32'h0200_0000
) (
  input  logic [AW-1:0] va_i,
  input  logic [AW-1:0] pid_i,
  output logic [AW-1:0] va_o
);
  localparam logic [AW-1:0] LIM = AW'(LIMIT);
  always_comb va_o = (va_i < LIM) ? va_i + pid_i : va_i;
endmodule

// File: rtl/pw_perm.sv
module pw_perm (
  input  logic [1:0] dom_acc,
  input  logic [1:0] ap,
  input  logic [1:0] ap0_mode,
  input  logic       is_user,
  output logic       rd_ok,
  output logic       wr_ok
);
  always_comb begin
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    if (dom_acc == 2'd3) begin
      rd_ok = 1'b1;
      wr_ok = 1'b1;
    end else begin
      unique case (ap)
        2'd3: begin rd_ok = 1'b1;     wr_ok = 1'b1;     end
        2'd2: begin rd_ok = 1'b1;     wr_ok = !is_user; end
        2'd1: begin rd_ok = !is_user; wr_ok = !is_user; end
        default: begin
          wr_ok = 1'b0;
          unique case (ap0_mode)
            2'd1:    rd_ok = !is_user;
            2'd2:    rd_ok = 1'b1;
            default: rd_ok = 1'b0;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/pw_decode.sv
module pw_decode
  import pw_pkg::*;
(
  input  logic            mmu_on,
  input  logic [VA_W-1:0] va,
  input  logic [VA_W-1:0] d1,
  input  logic [VA_W-1:0] d2,
  input  logic [1:0]      acc,
  input  logic            is_user,
  input  logic [VA_W-1:0] dacr,
  input  logic [1:0]      ap0_mode,
  output logic            fault_o,
  output logic [VA_W-1:0] status_o,
  output logic [VA_W-1:0] pa_o,
  output logic            rd_o,
  output logic            wr_o
);
  logic [DOM_W-1:0] dom;
  logic [1:0]       df, ap, sub_ap;
  logic             walk_fault, is_page, p_rd, p_wr, granted, deny;
  logic [FC_W-1:0]  walk_code, code;
  logic [VA_W-1:0]  pa;

  always_comb begin
    unique case (va[11:10])
      2'd0: sub_ap = d2[5:4];
      2'd1: sub_ap = d2[7:6];
      2'd2: sub_ap = d2[9:8];
      default: sub_ap = d2[11:10];
    endcase
  end

  // descriptor interpretation
  always_comb begin
    dom        = d1[8:5];
    df         = dom_field(dacr, dom);
    walk_fault = 1'b0;
    walk_code  = '0;
    pa         = '0;
    ap         = 2'd0;
    is_page    = 1'b0;
    if (!mmu_on) begin
      pa = va;
    end else if (d1[1:0] == 2'b00) begin
      walk_fault = 1'b1;
      walk_code  = FC_SEC_XLAT;
    end else if (!df[0]) begin
      walk_fault = 1'b1;
      walk_code  = (d1[1:0] == 2'b10) ? FC_SEC_DOM : FC_PAGE_DOM;
    end else if (d1[1:0] == 2'b10) begin
      pa = {d1[31:20], va[19:0]};
      ap = d1[11:10];
    end else begin
      is_page = 1'b1;
      unique case (d2[1:0])
        2'd0: begin walk_fault = 1'b1; walk_code = FC_PAGE_XLAT; end
        2'd1: begin pa = {d2[31:16], va[15:0]}; ap = sub_ap; end
        2'd2: begin pa = {d2[31:12], va[11:0]}; ap = sub_ap; end
        default: begin
          if (d1[1:0] == 2'b01) begin
            walk_fault = 1'b1;
            walk_code  = FC_PAGE_XLAT;
          end else begin
            pa = {d2[31:10], va[9:0]};
            ap = d2[5:4];
          end
        end
      endcase
    end
  end

  pw_perm u_perm (
    .dom_acc (df),
    .ap      (ap),
    .ap0_mode(ap0_mode),
    .is_user (is_user),
    .rd_ok   (p_rd),
    .wr_ok   (p_wr)
  );

  // final verdict
  always_comb begin
    granted  = (acc == ACC_WRITE) ? p_wr : p_rd;
    deny     = mmu_on && !walk_fault && !granted;
    fault_o  = walk_fault || deny;
    code     = walk_fault ? walk_code : (is_page ? FC_PAGE_PERM : FC_SEC_PERM);
    status_o = fault_o ? {{(VA_W-DOM_W-FC_W){1'b0}}, dom, code} : '0;
    pa_o     = fault_o ? '0 : pa;
    rd_o     = !mmu_on || (!fault_o && p_rd);
    wr_o     = !mmu_on || (!fault_o && p_wr);
  end
endmodule

// File: rtl/pagewalk_unit.sv
module pagewalk_unit
  import pw_pkg::*;
#(
  parameter logic [31:0] REMAP_LIMIT = 32'h0200_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic [1:0]  req_acc,
  input  logic        req_user,
  input  logic        cfg_mmu_on,
  input  logic [1:0]  cfg_ap0_mode,
  input  logic [31:0] cfg_ttb,
  input  logic [31:0] cfg_dacr,
  input  logic [31:0] cfg_pid,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        res_valid,
  input  logic        res_ready,
  output logic        res_fault,
  output logic [31:0] res_pa,
  output logic        res_rd_ok,
  output logic        res_wr_ok,
  output logic [31:0] res_status,
  output logic [31:0] data_fstat,
  output logic [31:0] data_faddr,
  output logic [31:0] inst_fstat,
  output logic [31:0] inst_faddr
);
  localparam int TB_LO = 14;

  walk_state_t           st;
  logic [VA_W-1:0]       va_q, veff_q, dacr_q, d1_q, d2_q, veff_w;
  logic [VA_W-1:TB_LO]   ttb_q;
  logic [1:0]            acc_q, ap0_q;
  logic                  user_q, mmu_q;
  logic                  dc_fault, dc_rd, dc_wr;
  logic [VA_W-1:0]       dc_status, dc_pa;

  pw_remap #(.AW(VA_W), .LIMIT(REMAP_LIMIT)) u_remap (
    .va_i (req_va),
    .pid_i(cfg_pid),
    .va_o (veff_w)
  );

  pw_decode u_decode (
    .mmu_on  (mmu_q),
    .va      (veff_q),
    .d1      (d1_q),
    .d2      (d2_q),
    .acc     (acc_q),
    .is_user (user_q),
    .dacr    (dacr_q),
    .ap0_mode(ap0_q),
    .fault_o (dc_fault),
    .status_o(dc_status),
    .pa_o    (dc_pa),
    .rd_o    (dc_rd),
    .wr_o    (dc_wr)
  );

  assign req_ready     = (st == S_IDLE);
  assign res_valid     = (st == S_DONE);
  assign mem_req_valid = (st == S_L1_REQ) || (st == S_L2_REQ);
  assign mem_addr      = (st == S_L2_REQ)
                       ? {d1_q[31:10], veff_q[19:12], 2'b00}
                       : {ttb_q, veff_q[31:20], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      va_q       <= '0;
      veff_q     <= '0;
      dacr_q     <= '0;
      ttb_q      <= '0;
      d1_q       <= '0;
      d2_q       <= '0;
      acc_q      <= '0;
      ap0_q      <= '0;
      user_q     <= 1'b0;
      mmu_q      <= 1'b0;
      res_fault  <= 1'b0;
      res_pa     <= '0;
      res_rd_ok  <= 1'b0;
      res_wr_ok  <= 1'b0;
      res_status <= '0;
      data_fstat <= '0;
      data_faddr <= '0;
      inst_fstat <= '0;
      inst_faddr <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          veff_q <= veff_w;
          acc_q  <= req_acc;
          user_q <= req_user;
          mmu_q  <= cfg_mmu_on;
          ap0_q  <= cfg_ap0_mode;
          ttb_q  <= cfg_ttb[VA_W-1:TB_LO];
          dacr_q <= cfg_dacr;
          d1_q   <= '0;
          d2_q   <= '0;
          st     <= cfg_mmu_on ? S_L1_REQ : S_CHECK;
        end
        S_L1_REQ: if (mem_req_ready) st <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rsp_valid) begin
          d1_q <= mem_rsp_data;
          st   <= l1_needs_l2(mem_rsp_data, dacr_q) ? S_L2_REQ : S_CHECK;
        end
        S_L2_REQ: if (mem_req_ready) st <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rsp_valid) begin
          d2_q <= mem_rsp_data;
          st   <= S_CHECK;
        end
        S_CHECK: begin
          res_fault  <= dc_fault;
          res_pa     <= dc_pa;
          res_rd_ok  <= dc_rd;
          res_wr_ok  <= dc_wr;
          res_status <= dc_status;
          if (dc_fault) begin
            if (acc_q == ACC_FETCH) begin
              inst_fstat <= dc_status;
              inst_faddr <= va_q;
            end else begin
              data_fstat <= dc_status;
              data_faddr <= va_q;
            end
          end
          st <= S_DONE;
        end
        default: if (res_ready) st <= S_IDLE;
      endcase
    end
  end

  // R11: a pending descriptor read holds until accepted
  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));

  // R11: the offered result holds until taken
  p_res_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_pa) && $stable(res_fault)
      && $stable(res_status) && $stable(res_rd_ok) && $stable(res_wr_ok));

  // R11: nothing in flight while idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !res_valid);

  // R2: a disabled translation never reads memory
  p_off_nomem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && !mmu_q |-> !mem_req_valid);

  // R9: a faulting result grants no rights
  p_fault_norights_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> !res_rd_ok && !res_wr_ok && res_pa == '0);

  // R10: status is zero without a fault
  p_status_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault |-> res_status == '0);

  // R10: the pair of the other access kind stays unchanged
  p_inst_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) && acc_q != ACC_FETCH |-> $stable(inst_fstat) && $stable(inst_faddr));
  p_data_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) && acc_q == ACC_FETCH |-> $stable(data_fstat) && $stable(data_faddr));
endmodule

// File: tb/pagewalk_unit_bench.sv
`timescale 1ns/1ps
module pagewalk_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic        cfg_mmu_on = 1'b0;
  logic [1:0]  cfg_ap0_mode = '0;
  logic [31:0] cfg_ttb = '0, cfg_dacr = '0, cfg_pid = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_fault, res_rd_ok, res_wr_ok;
  logic [31:0] res_pa, res_status, data_fstat, data_faddr, inst_fstat, inst_faddr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [31:0] e_ifs = 0, e_ifa = 0, e_dfs = 0, e_dfa = 0;

  always #2.5 clk = ~clk;

  pagewalk_unit u_pagewalk_unit (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic void model(input logic [31:0] va, input logic [1:0] acc, input logic user,
      input logic [31:0] d1, input logic [31:0] d2,
      output logic fault, output logic [31:0] stat, output logic [31:0] pa,
      output logic rd, output logic wr, output int nrd,
      output logic [31:0] a1, output logic [31:0] a2);
    logic [31:0] v;
    int dom, df, t1, t2, ap, sp, code;
    logic page, need;
    v = (va < 32'h0200_0000) ? va + cfg_pid : va;
    fault = 0; stat = 0; pa = 0; rd = 0; wr = 0; nrd = 0; a1 = 0; a2 = 0;
    code = 0; page = 0; ap = 0;
    if (!cfg_mmu_on) begin
      pa = v; rd = 1; wr = 1;
    end else begin
      nrd = 1;
      a1 = (cfg_ttb & 32'hFFFF_C000) | ((v >> 20) << 2);
      dom = int'(d1[8:5]);
      df = int'((cfg_dacr >> (2 * dom)) & 3);
      t1 = int'(d1[1:0]);
      if (t1 == 0) begin fault = 1; code = 5; end
      else if (df == 0 || df == 2) begin fault = 1; code = (t1 == 2) ? 9 : 11; end
      else if (t1 == 2) begin
        pa = (d1 & 32'hFFF0_0000) | (v & 32'h000F_FFFF);
        ap = int'(d1[11:10]);
      end else begin
        page = 1; nrd = 2;
        a2 = (d1 & 32'hFFFF_FC00) | (((v >> 12) & 255) << 2);
        t2 = int'(d2[1:0]);
        sp = int'(v[11:10]);
        if (t2 == 0) begin fault = 1; code = 7; end
        else if (t2 == 1) begin pa = (d2 & 32'hFFFF_0000) | (v & 32'hFFFF); ap = int'((d2 >> (4 + 2 * sp)) & 3); end
        else if (t2 == 2) begin pa = (d2 & 32'hFFFF_F000) | (v & 32'hFFF); ap = int'((d2 >> (4 + 2 * sp)) & 3); end
        else if (t1 == 1) begin fault = 1; code = 7; end
        else begin pa = (d2 & 32'hFFFF_FC00) | (v & 32'h3FF); ap = int'(d2[5:4]); end
      end
      if (!fault) begin
        if (df == 3) begin rd = 1; wr = 1; end
        else if (ap == 3) begin rd = 1; wr = 1; end
        else if (ap == 2) begin rd = 1; wr = !user; end
        else if (ap == 1) begin rd = !user; wr = !user; end
        else begin wr = 0; rd = (cfg_ap0_mode == 2) || (cfg_ap0_mode == 1 && !user); end
        need = (acc == 2'd1) ? wr : rd;
        if (!need) begin fault = 1; code = page ? 15 : 13; end
      end
      if (fault) begin
        stat = 32'(code) | (32'(dom) << 4);
        pa = 0; rd = 0; wr = 0;
      end
    end
  endfunction

  task automatic run(input logic [31:0] va, input logic [1:0] acc, input logic user,
                     input logic [31:0] d1, input logic [31:0] d2, input string tag);
    logic ef, er, ew;
    logic [31:0] es, ep, a1, a2, snap;
    int en, nrd;
    model(va, acc, user, d1, d2, ef, es, ep, er, ew, en, a1, a2);
    @(negedge clk);
    req_va = va; req_acc = acc; req_user = user; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11 busy", 32'(req_ready), 0);
    nrd = 0;
    while (!res_valid) begin
      if (mem_req_valid) begin
        nrd++;
        if (nrd == 1) chk(mem_addr == a1, "R3 l1 addr", mem_addr, a1);
        else          chk(mem_addr == a2, "R7 l2 addr", mem_addr, a2);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data = (nrd == 1) ? d1 : d2;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    chk(nrd == en, {tag, " read count"}, 32'(nrd), 32'(en));
    chk(res_fault == ef, {tag, " fault"}, 32'(res_fault), 32'(ef));
    chk(res_pa == ep, {tag, " pa"}, res_pa, ep);
    chk({res_rd_ok, res_wr_ok} == {er, ew}, {tag, " rights"}, 32'({res_rd_ok, res_wr_ok}), 32'({er, ew}));
    chk(res_status == es, {tag, " status R10"}, res_status, es);
    snap = res_pa;
    @(negedge clk);
    chk(res_valid && res_pa == snap, "R11 hold", res_pa, snap);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(req_ready && !res_valid, "R11 release", 32'({req_ready, res_valid}), 32'h2);
    if (ef) begin
      if (acc == 2'd2) begin e_ifs = es; e_ifa = va; end
      else begin e_dfs = es; e_dfa = va; end
    end
    chk(inst_fstat == e_ifs && inst_faddr == e_ifa, "R10 inst pair", inst_fstat, e_ifs);
    chk(data_fstat == e_dfs && data_faddr == e_dfa, "R10 data pair", data_fstat, e_dfs);
  endtask

  function automatic logic [31:0] set_dom(input int dn, input int df);
    logic [31:0] w;
    w = 32'h5555_5555;
    w[2*dn +: 2] = 2'(df);
    return w;
  endfunction

  initial begin
    int n;
    logic [31:0] va, d1, d2;
    n = 0;
    repeat (3) @(negedge clk);
    chk(req_ready && !res_valid && !mem_req_valid, "reset R11", 32'({req_ready, res_valid, mem_req_valid}), 32'h4);
    chk(inst_fstat == 0 && data_fstat == 0 && inst_faddr == 0 && data_faddr == 0, "reset R10", inst_fstat | data_fstat, 0);
    rst_n = 1'b1;
    cfg_pid = 32'h0130_0040;

    // R2 and R1: translation disabled, addresses around the remap limit
    cfg_mmu_on = 1'b0;
    for (int k = 0; k < 8; k++)
      run(32'(k) * 32'h0080_0000 + 32'(k * 12345), 2'(k % 3), k[0], 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 off");
    run(32'h01FF_FFFF, 2'd0, 1'b0, 0, 0, "R1 below limit");
    run(32'h0200_0000, 2'd1, 1'b0, 0, 0, "R1 at limit");

    // sections: R5 R6 R9 across domain field, AP, selector, user, access
    cfg_mmu_on = 1'b1;
    cfg_ttb = 32'h8000_5ABC;
    for (int df = 0; df < 4; df++)
      for (int ap = 0; ap < 4; ap++)
        for (int m = 0; m < 4; m++)
          for (int u = 0; u < 2; u++)
            for (int a = 0; a < 3; a++) begin
              int dn;
              n++;
              dn = (df * 4 + ap + m) % 16;
              cfg_dacr = set_dom(dn, df);
              cfg_ap0_mode = 2'(m);
              va = 32'(n) * 32'h9E37_79B9;
              if (n % 7 == 0) va = va & 32'h01FF_FFFF;
              d1 = (32'(n) * 32'h0130_0000 & 32'hFFF0_0000) | (32'(ap) << 10) | (32'(dn) << 5) | 32'h2;
              run(va, 2'(a), u[0], d1, 32'hDEAD_BEEF, "R6 section");
            end

    // R4: first-level type 0
    for (int k = 0; k < 6; k++) begin
      cfg_dacr = 32'hFFFF_FFFF;
      run(32'h4000_0000 + 32'(k) * 32'h0110_0000, 2'(k % 3), 1'b0,
          32'hABC0_0C00 | (32'(k + 3) << 5), 0, "R4 l1 fault");
    end

    // R5: page-table domain faults and manager override
    for (int t1 = 1; t1 < 4; t1 += 2)
      for (int df = 0; df < 4; df++) begin
        cfg_dacr = set_dom(6, df);
        cfg_ap0_mode = 2'd0;
        run(32'h7654_3210, 2'd1, 1'b1, 32'h1234_5800 | (32'd6 << 5) | 32'(t1),
            32'h8888_8002, "R5 page domain");
      end

    // pages: R7 R8 R9 across type, sub-page, AP, user, access
    for (int t1 = 1; t1 < 4; t1 += 2)
      for (int t2 = 0; t2 < 4; t2++)
        for (int sp = 0; sp < 4; sp++)
          for (int ap = 0; ap < 4; ap++)
            for (int u = 0; u < 2; u++)
              for (int a = 0; a < 3; a++) begin
                int dn, df;
                n++;
                dn = (n * 5) % 16;
                df = ((ap + sp + u) % 3 == 0) ? 3 : 1;
                cfg_dacr = set_dom(dn, df);
                cfg_ap0_mode = 2'((sp + a) % 4);
                va = 32'(n) * 32'h6C07_8965;
                if (n % 5 == 0) va = va & 32'h01FF_FFFF;
                va[11:10] = 2'(sp);
                d1 = (32'(n) * 32'h0004_3C00 & 32'hFFFF_FC00) | (32'(dn) << 5) | 32'(t1);
                d2 = (32'(n) * 32'h7351_9000 & 32'hFFFF_F000) | 32'(t2);
                for (int k = 0; k < 4; k++)
                  d2[4 + 2*k +: 2] = (k == sp) ? 2'(ap) : ~2'(ap);
                run(va, 2'(a), u[0], d1, d2, "R8 page");
              end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule